// File: doc/BRIEF.md
# Lockable SMM RAM Window Control Register

This block holds one 8-bit control register that decides how the processor reaches hidden system-management memory. A 3-bit code in the register picks a 64 KB window. The window appears at a host segment and is backed by a DRAM segment. The two segments are either the same or, for the upper segments, aliased onto DRAM at 0xA0000. Two further flags tell the downstream memory routing two things: whether the window is open to ordinary, non-SMM accesses, and whether SMM-mode accesses may use it.

Firmware programs the register with single-cycle write strobes. Writing the lock bit as one makes the register read-only, with one exception: the close bit stays writable until the next hard reset. All outputs are decoded combinationally from the stored state. They take their new values together, in the cycle after the accepting clock edge, and no mixed old/new combination is ever visible. The register's only data interface is a single-cycle configuration write. That write has no back-pressure, so it is a plain strobe and needs no valid/ready pair.

Top module: `smram_win_ctl`

## Requirements
- R1: After reset, the register value is 0x00, `locked` is 0, `win_en`, `host_base`, `dram_base` and `ext_open` are 0, and `smm_en` is 1.
- R2: While unlocked, a write stores data bits 6:4 and 2:0, and keeps the stored bits 7 and 3, which stay 0 after reset.
- R3: An unlocked write with data bit 4 (the lock bit) set to 1 raises `locked` and stores bit 6 as 0, whatever the data holds there.
- R4: While locked, a write changes only bit 5 (the close bit), and every other register bit keeps its value.
- R5: Once set, `locked` stays 1 until reset, and reset clears it and the register to 0x00. `reg_rd` bit 4 always equals `locked`.
- R6: With register bits 2:0 equal to 0 or 1, `win_en` is 0 and both bases read 0.
- R7: Code 2 gives host and DRAM base 0xA0000, and code 3 gives host and DRAM base 0xB0000. `win_en` is 1 for both.
- R8: Codes 4, 5, 6 and 7 give host base 0xC0000, 0xD0000, 0xE0000 and 0xF0000 in that order. Each has DRAM base 0xA0000 and `win_en` 1.
- R9: `ext_open` is 1 exactly when register bits 6:4 equal binary 100.
- R10: `smm_en` is 1 exactly when register bit 5 is 0.
- R11: In a cycle without a write strobe, the register and all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| reg_rd | output | 8 | Readable register value, bit 4 shows the lock |
| locked | output | 1 | Lock status |
| host_base | output | ADDR_W | Host-side window base address (20 by default) |
| dram_base | output | ADDR_W | DRAM-side window base address |
| win_en | output | 1 | Window enabled, 64 KB in size |
| ext_open | output | 1 | Window open to non-SMM accesses |
| smm_en | output | 1 | Window usable by SMM-mode accesses |

## Verification
The window code is swept through all eight values. Bits 7 and 3 of the write data are set to one during the sweep, so the sweep separates the disabled, identity and aliased mappings and also shows that the fixed bits are never written. The access-field patterns 100, 110 and 010 tell the open condition apart from a set close bit. Writes of all ones and all zeros after the lock show that only the close bit moves. A lock written together with bit 6 shows that the forced clear of bit 6 happens in the same write. A second lock, issued after a mid-run reset, shows that only reset releases the lock.

// File: rtl/smram_ctl_pkg.sv
package smram_ctl_pkg;
  localparam int unsigned REG_W = 8;

  // access field: [2] open request (bit 6), [1] close (bit 5), [0] lock (bit 4)
  localparam int unsigned ACC_OPEN  = 2;
  localparam int unsigned ACC_CLOSE = 1;
  localparam int unsigned ACC_LOCK  = 0;

  typedef enum logic [2:0] {
    WIN_OFF0  = 3'd0,
    WIN_OFF1  = 3'd1,
    WIN_SEG_A = 3'd2,
    WIN_SEG_B = 3'd3,
    WIN_ALI_C = 3'd4,
    WIN_ALI_D = 3'd5,
    WIN_ALI_E = 3'd6,
    WIN_ALI_F = 3'd7
  } win_code_e;

  typedef struct packed {
    logic       fix_hi;   // bit 7, never written
    logic [2:0] acc;      // bits 6:4
    logic       fix_lo;   // bit 3, never written
    logic [2:0] win;      // bits 2:0
  } smram_reg_t;

  localparam logic [2:0] ACC_OPEN_PATTERN = 3'b100;
endpackage

// File: rtl/smram_ctl_store.sv
module smram_ctl_store
  import smram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  smram_reg_t wr_val,
  output smram_reg_t cur,
  output logic       lock_q
);
  smram_reg_t nxt;
  logic       lock_d;

  always_comb begin
    nxt    = cur;
    lock_d = lock_q;
    if (wr_en) begin
      if (lock_q) begin
        nxt.acc[ACC_CLOSE] = wr_val.acc[ACC_CLOSE];
      end else begin
        nxt.acc = wr_val.acc;
        nxt.win = wr_val.win;
        if (wr_val.acc[ACC_LOCK]) begin
          lock_d            = 1'b1;
          nxt.acc[ACC_OPEN] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      lock_q <= 1'b0;
    end else begin
      cur    <= nxt;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/smram_win_decode.sv
module smram_win_decode
  import smram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic [2:0]        code,
  output logic              win_en,
  output logic [ADDR_W-1:0] host_base,
  output logic [ADDR_W-1:0] dram_base
);
  localparam int unsigned SEG_W = ADDR_W - WIN_LOG2;
  localparam logic [SEG_W-1:0] SEG_A = SEG_W'(4'hA);
  localparam logic [SEG_W-1:0] SEG_B = SEG_W'(4'hB);
  localparam logic [SEG_W-1:0] SEG_C = SEG_W'(4'hC);

  logic [SEG_W-1:0] host_seg, dram_seg;

  always_comb begin
    win_en   = 1'b1;
    host_seg = '0;
    dram_seg = '0;
    unique case (win_code_e'(code))
      WIN_OFF0, WIN_OFF1: win_en = 1'b0;
      WIN_SEG_A: begin host_seg = SEG_A; dram_seg = SEG_A; end
      WIN_SEG_B: begin host_seg = SEG_B; dram_seg = SEG_B; end
      default: begin
        host_seg = SEG_C + SEG_W'(code[1:0]);
        dram_seg = SEG_A;
      end
    endcase
  end

  assign host_base = {host_seg, {WIN_LOG2{1'b0}}};
  assign dram_base = {dram_seg, {WIN_LOG2{1'b0}}};
endmodule

// File: rtl/smram_access_flags.sv
module smram_access_flags
  import smram_ctl_pkg::*;
(
  input  logic [2:0] acc,
  output logic       ext_open,
  output logic       smm_en
);
  assign ext_open = (acc == ACC_OPEN_PATTERN);
  assign smm_en   = ~acc[ACC_CLOSE];
endmodule

// File: rtl/smram_win_ctl.sv
module smram_win_ctl
  import smram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        reg_rd,
  output logic              locked,
  output logic [ADDR_W-1:0] host_base,
  output logic [ADDR_W-1:0] dram_base,
  output logic              win_en,
  output logic              ext_open,
  output logic              smm_en
);
  smram_reg_t cur;
  smram_reg_t rd_view;

  smram_ctl_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (smram_reg_t'(wr_data)),
    .cur    (cur),
    .lock_q (locked)
  );

  smram_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
    .code      (cur.win),
    .win_en    (win_en),
    .host_base (host_base),
    .dram_base (dram_base)
  );

  smram_access_flags u_flags (
    .acc      (cur.acc),
    .ext_open (ext_open),
    .smm_en   (smm_en)
  );

  always_comb begin
    rd_view              = cur;
    rd_view.acc[ACC_LOCK] = locked;
  end
  assign reg_rd = rd_view;
endmodule

// File: rtl/smram_win_ctl_chk.sv
module smram_win_ctl_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        reg_rd,
  input logic              locked,
  input logic [ADDR_W-1:0] host_base,
  input logic [ADDR_W-1:0] dram_base,
  input logic              win_en,
  input logic              ext_open,
  input logic              smm_en
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R5
  AST_LOCKED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (reg_rd[7:6] == $past(reg_rd[7:6])) && (reg_rd[4:0] == $past(reg_rd[4:0]))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_rd) && $stable(host_base) && $stable(ext_open)); // R11
  AST_NO_OPEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !ext_open); // R3
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (host_base == '0) && (dram_base == '0)); // R6
  AST_DRAM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |-> (dram_base[ADDR_W-1 -: 4] == 4'hA) || (dram_base == host_base)); // R8
  AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd[4] == locked); // R5
  AST_SMM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    smm_en != reg_rd[5]); // R10
endmodule

bind smram_win_ctl smram_win_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .reg_rd    (reg_rd),
  .locked    (locked),
  .host_base (host_base),
  .dram_base (dram_base),
  .win_en    (win_en),
  .ext_open  (ext_open),
  .smm_en    (smm_en)
);

// File: tb/smram_win_ctl_test.sv
`timescale 1ns/1ps
module smram_win_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  reg_rd;
  logic        locked;
  logic [19:0] host_base, dram_base;
  logic        win_en, ext_open, smm_en;

  int compared = 0;
  int mismatched = 0;
  int m_reg = 0;
  int m_lock = 0;

  always #2.5 clk = ~clk;

  smram_win_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .reg_rd(reg_rd), .locked(locked), .host_base(host_base),
    .dram_base(dram_base), .win_en(win_en), .ext_open(ext_open), .smm_en(smm_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int code, e_host, e_dram, e_en;
    code = m_reg & 7;
    e_en = (code >= 2) ? 1 : 0;
    case (code)
      2: begin e_host = 'hA0000; e_dram = 'hA0000; end
      3: begin e_host = 'hB0000; e_dram = 'hB0000; end
      4: begin e_host = 'hC0000; e_dram = 'hA0000; end
      5: begin e_host = 'hD0000; e_dram = 'hA0000; end
      6: begin e_host = 'hE0000; e_dram = 'hA0000; end
      7: begin e_host = 'hF0000; e_dram = 'hA0000; end
      default: begin e_host = 0; e_dram = 0; end
    endcase
    chk(req, "reg_rd", int'(reg_rd), m_reg);
    chk("R5", "locked", int'(locked), m_lock);
    chk((code < 2) ? "R6" : (code < 4) ? "R7" : "R8", "win_en", int'(win_en), e_en);
    chk((code < 2) ? "R6" : (code < 4) ? "R7" : "R8", "host_base", int'(host_base), e_host);
    chk((code < 2) ? "R6" : (code < 4) ? "R7" : "R8", "dram_base", int'(dram_base), e_dram);
    chk("R9", "ext_open", int'(ext_open), (((m_reg >> 4) & 7) == 4) ? 1 : 0);
    chk("R10", "smm_en", int'(smm_en), ((m_reg & 'h20) == 0) ? 1 : 0);
  endtask

  // one clock: drive, let the edge pass, step the model, compare mid-cycle
  task automatic cycle(input bit we, input int d, input string req);
    wr_en = we;
    wr_data = 8'(d);
    @(posedge clk);
    #1;
    if (we) begin
      if (m_lock != 0) begin
        m_reg = (m_reg & 'hDF) | (d & 'h20);
      end else begin
        m_reg = (m_reg & 'h88) | (d & 'h77);
        if ((d & 'h10) != 0) begin
          m_lock = 1;
          m_reg = m_reg & ~'h40;
        end
      end
    end
    wr_en = 1'b0;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_reg = 0;
    m_lock = 0;
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    // R2, R6, R7, R8: sweep all codes with fixed bits set in the data
    for (int c = 0; c < 8; c++) cycle(1'b1, 'h88 | c, "R2");
    // R9 / R10 access patterns
    cycle(1'b1, 'h42, "R9");
    cycle(1'b1, 'h65, "R9");
    cycle(1'b1, 'h27, "R10");
    // R11 idle cycles
    for (int i = 0; i < 3; i++) cycle(1'b0, 'hFF, "R11");
    // R3 lock with open bit in data
    cycle(1'b1, 'h55, "R3");
    // R4 locked writes
    cycle(1'b1, 'hFF, "R4");
    cycle(1'b1, 'h00, "R4");
    cycle(1'b1, 'h47, "R4");
    cycle(1'b1, 'h20, "R4");
    cycle(1'b0, 'h00, "R11");
    // R5 reset releases lock
    hard_reset();
    cycle(1'b1, 'h43, "R5");
    cycle(1'b1, 'h17, "R3");
    cycle(1'b1, 'h03, "R4");
    hard_reset();
    cycle(1'b1, 'h46, "R2");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule